// File: doc/BRIEF.md
# BCD/Binary Interval Down-Counter Channel

This block is a single timer channel. A host writes a 16-bit initial count and a counting-mode bit, then arms the channel with a separate command. Once armed, the channel steps its count down by one on every rising edge of a slow count clock, but only while the gate input is high. The count runs either as a plain 16-bit binary number or as four packed decimal digits. When the count reaches zero, the OUT line drops for one count-clock period. This pulse can serve as an interrupt. The channel then reloads the initial count and runs again.

All state is registered on a fast system clock. The count clock is an ordinary input that is sampled on that clock, and its rising edges are detected there. A snapshot command freezes a copy of the count in a holding register. The host can then read that copy a byte at a time while the live count keeps moving.

Top module: `dcnt_channel`

## Requirements
- R1: After reset, OUT is high, the count reads 0, and the channel is not armed.
- R2: A load stores the initial count and the mode bit (bcd_i=1 selects decimal, 0 selects binary), sets the live count to the initial count and disarms the channel. The count does not move until arm_i is asserted after a load.
- R3: In binary mode, each count-clock rising edge seen while gate_i is high and the channel is armed lowers the count by one. A count of 0 steps to 0xFFFF.
- R4: While gate_i is low and OUT is high, count-clock edges leave the count unchanged.
- R5: In decimal mode, each nibble is one digit (bits 3:0 are the lowest digit). A step borrows from the next higher digit, and a digit of 0 becomes 9. 0x0000 steps to 0x9999. Loaded decimal values must hold digits 0 to 9 only.
- R6: The step that makes the count zero drives OUT low. OUT stays low until the next count-clock rising edge, whatever gate_i is doing. That edge reloads the initial count and returns OUT high.
- R7: latch_i copies the live count into a holding register. Reads then return the held value until its high byte has been read, while counting continues.
- R8: latch_i is ignored while a held value has not yet been fully read.
- R9: rd_data_o shows the low byte first. Each rd_i pulse toggles the output between the low and high byte. A load resets the output to the low byte and drops any held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_clk_i | input | 1 | Count clock, sampled; rising edges step the count |
| gate_i | input | 1 | Count enable |
| load_i | input | 1 | Load strobe for initial count and mode |
| load_val_i | input | 16 | Initial count |
| bcd_i | input | 1 | Mode bit captured at load: 1 decimal, 0 binary |
| arm_i | input | 1 | Arm command, effective after a load |
| latch_i | input | 1 | Snapshot command |
| rd_i | input | 1 | Byte read strobe |
| rd_data_o | output | 8 | Selected byte of held or live count |
| out_o | output | 1 | Terminal-count output, idles high |

## Verification
The assertions watch on every cycle that:
- the count stays put while the gate is low or the channel is unarmed;
- every digit remains valid in decimal mode;
- OUT is low only with a zero count and changes only on a count-clock edge;
- a held snapshot never changes.

The actual arithmetic can only be shown by the bench scenarios: the borrow chain across digits, the wrap to 0xFFFF and to 0x9999, and the reload value after the terminal pulse. The same holds for the read sequence, which shows that the snapshot is taken at the right moment and that reads fall back to the live count only after the high byte.

// File: rtl/dcnt_pkg.sv
`timescale 1ns/1ps
package dcnt_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DIG_W  = 4;
  typedef enum logic {MODE_BIN = 1'b0, MODE_BCD = 1'b1} cnt_mode_e;
endpackage

// File: rtl/dcnt_edge.sv
`timescale 1ns/1ps
module dcnt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/dcnt_dec.sv
`timescale 1ns/1ps
module dcnt_dec
  import dcnt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic [W-1:0] val_i,
  input  cnt_mode_e    mode_i,
  output logic [W-1:0] nxt_o
);
  localparam int unsigned ND = W / DIG_W;

  logic [ND:0]  brw;
  logic [W-1:0] bcd_nxt;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < ND; g++) begin : g_dig
    logic [DIG_W-1:0] dig;
    assign dig = val_i[g*DIG_W +: DIG_W];
    // zero digit wraps to nine and passes the borrow upward
    assign bcd_nxt[g*DIG_W +: DIG_W] = !brw[g]   ? dig :
                                       (dig == '0) ? DIG_W'(9) : dig - 1'b1;
    assign brw[g+1] = brw[g] & (dig == '0);
  end

  assign nxt_o = (mode_i == MODE_BCD) ? bcd_nxt : val_i - 1'b1;
endmodule

// File: rtl/dcnt_snap.sv
`timescale 1ns/1ps
module dcnt_snap
  import dcnt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              latch_i,
  input  logic              rd_i,
  input  logic [W-1:0]      live_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              holding_o,
  output logic [W-1:0]      hold_o
);
  logic [W-1:0] hold_q;
  logic         holding_q;
  logic         hi_q;
  logic [W-1:0] src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= '0;
      holding_q <= 1'b0;
      hi_q      <= 1'b0;
    end else if (clr_i) begin
      holding_q <= 1'b0;
      hi_q      <= 1'b0;
    end else if (latch_i && !holding_q) begin
      hold_q    <= live_i;
      holding_q <= 1'b1;
      hi_q      <= 1'b0;
    end else if (rd_i) begin
      hi_q <= ~hi_q;
      if (hi_q) holding_q <= 1'b0;
    end
  end

  assign src       = holding_q ? hold_q : live_i;
  assign data_o    = hi_q ? src[W-1 -: BYTE_W] : src[BYTE_W-1:0];
  assign holding_o = holding_q;
  assign hold_o    = hold_q;
endmodule

// File: rtl/dcnt_channel.sv
`timescale 1ns/1ps
module dcnt_channel
  import dcnt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_clk_i,
  input  logic              gate_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  input  logic              bcd_i,
  input  logic              arm_i,
  input  logic              latch_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              out_o
);
  logic [CNT_W-1:0] cnt_q, init_q, cnt_nxt, hold_val;
  cnt_mode_e        mode_q;
  logic             loaded_q, armed_q, out_q, tick, holding;

  dcnt_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (cnt_clk_i),
    .rise_o (tick)
  );

  dcnt_dec #(.W(CNT_W)) u_dec (
    .val_i  (cnt_q),
    .mode_i (mode_q),
    .nxt_o  (cnt_nxt)
  );

  dcnt_snap #(.W(CNT_W)) u_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (load_i),
    .latch_i   (latch_i),
    .rd_i      (rd_i),
    .live_i    (cnt_q),
    .data_o    (rd_data_o),
    .holding_o (holding),
    .hold_o    (hold_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      init_q   <= '0;
      mode_q   <= MODE_BIN;
      loaded_q <= 1'b0;
      armed_q  <= 1'b0;
      out_q    <= 1'b1;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      init_q   <= load_val_i;
      mode_q   <= bcd_i ? MODE_BCD : MODE_BIN;
      loaded_q <= 1'b1;
      armed_q  <= 1'b0;
      out_q    <= 1'b1;
    end else begin
      if (arm_i && loaded_q) armed_q <= 1'b1;
      if (armed_q && tick) begin
        if (!out_q) begin
          // terminal period over: reload regardless of gate
          cnt_q <= init_q;
          out_q <= 1'b1;
        end else if (gate_i) begin
          cnt_q <= cnt_nxt;
          if (cnt_nxt == '0) out_q <= 1'b0;
        end
      end
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/dcnt_channel_chk.sv
`timescale 1ns/1ps
module dcnt_channel_chk
  import dcnt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gate_i,
  input logic             load_i,
  input logic             out_o,
  input logic             tick,
  input logic             armed_q,
  input cnt_mode_e        mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             holding,
  input logic [CNT_W-1:0] hold_val
);
  localparam int unsigned ND = CNT_W / DIG_W;

  logic digits_ok;
  always_comb begin
    digits_ok = 1'b1;
    for (int i = 0; i < ND; i++)
      if (cnt_q[i*DIG_W +: DIG_W] > DIG_W'(9)) digits_ok = 1'b0;
  end

  AST_UNARMED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !load_i) |=> $stable(cnt_q)); // R2

  AST_GATE_LOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && out_o && !load_i) |=> $stable(cnt_q)); // R4

  AST_BCD_DIGITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BCD) |-> digits_ok); // R5

  AST_OUT_LOW_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_o |-> (cnt_q == '0)); // R6

  AST_OUT_LOW_UNTIL_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_o && !tick && !load_i) |=> !out_o); // R6

  AST_SNAP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holding |=> $stable(hold_val)); // R8
endmodule

bind dcnt_channel dcnt_channel_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .gate_i   (gate_i),
  .load_i   (load_i),
  .out_o    (out_o),
  .tick     (tick),
  .armed_q  (armed_q),
  .mode_q   (mode_q),
  .cnt_q    (cnt_q),
  .holding  (holding),
  .hold_val (hold_val)
);

// File: tb/dcnt_channel_tb.sv
`timescale 1ns/1ps
module dcnt_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_clk = 1'b0, gate = 1'b0, load = 1'b0, bcd = 1'b0;
  logic        arm = 1'b0, latch = 1'b0, rd = 1'b0;
  logic [15:0] load_val = '0;
  logic [7:0]  rd_data;
  logic        out;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dcnt_channel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(cnt_clk), .gate_i(gate),
    .load_i(load), .load_val_i(load_val), .bcd_i(bcd), .arm_i(arm),
    .latch_i(latch), .rd_i(rd), .rd_data_o(rd_data), .out_o(out)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [15:0] v, logic m);
    @(negedge clk); load = 1'b1; load_val = v; bcd = m;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic do_latch();
    @(negedge clk); latch = 1'b1;
    @(negedge clk); latch = 1'b0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_clk = 1'b1;
      @(negedge clk); cnt_clk = 1'b0;
    end
  endtask

  task automatic rd16(output logic [15:0] v);
    @(negedge clk); v[7:0] = rd_data; rd = 1'b1;
    @(negedge clk); rd = 1'b0; v[15:8] = rd_data; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    @(negedge clk);
    chk("R1 out", {15'd0, out}, 16'd1);
    rd16(v); chk("R1 count", v, 16'h0000);
    gate = 1'b1; tick(2);
    rd16(v); chk("R1 unarmed", v, 16'h0000);
  endtask

  task automatic t_binary();
    logic [15:0] v;
    gate = 1'b1;
    do_load(16'd5, 1'b0); tick(2);
    rd16(v); chk("R2 no arm", v, 16'd5);
    do_arm(); tick(4);
    rd16(v); chk("R3 step", v, 16'd1);
    chk("R6 out high", {15'd0, out}, 16'd1);
    tick(1);
    rd16(v); chk("R6 zero", v, 16'd0);
    chk("R6 out low", {15'd0, out}, 16'd0);
    tick(1);
    rd16(v); chk("R6 reload", v, 16'd5);
    chk("R6 out back", {15'd0, out}, 16'd1);
    do_load(16'd0, 1'b0); do_arm(); tick(1);
    rd16(v); chk("R3 wrap", v, 16'hFFFF);
  endtask

  task automatic t_gate();
    logic [15:0] v;
    do_load(16'd9, 1'b0); do_arm();
    gate = 1'b0; tick(3);
    rd16(v); chk("R4 hold", v, 16'd9);
    gate = 1'b1; tick(1);
    rd16(v); chk("R4 resume", v, 16'd8);
    do_load(16'd1, 1'b0); do_arm(); tick(1);
    chk("R6 low", {15'd0, out}, 16'd0);
    gate = 1'b0; tick(1);
    chk("R6 gate ignored", {15'd0, out}, 16'd1);
    rd16(v); chk("R6 reload gated", v, 16'd1);
    gate = 1'b1;
  endtask

  task automatic t_bcd();
    logic [15:0] v;
    do_load(16'h0100, 1'b1); do_arm(); tick(1);
    rd16(v); chk("R5 borrow", v, 16'h0099);
    tick(1);
    rd16(v); chk("R5 digit", v, 16'h0098);
    do_load(16'h0000, 1'b1); do_arm(); tick(1);
    rd16(v); chk("R5 wrap", v, 16'h9999);
    do_load(16'h1000, 1'b1); do_arm(); tick(1);
    rd16(v); chk("R5 chain", v, 16'h0999);
  endtask

  task automatic t_latch();
    logic [15:0] v;
    do_load(16'h1234, 1'b0); do_arm();
    do_latch(); tick(3);
    rd16(v); chk("R7 held", v, 16'h1234);
    rd16(v); chk("R7 live", v, 16'h1231);
    do_latch(); tick(1); do_latch(); tick(1);
    rd16(v); chk("R8 first kept", v, 16'h1231);
    rd16(v); chk("R8 live", v, 16'h122F);
  endtask

  task automatic t_order();
    do_load(16'hA55A, 1'b0);
    @(negedge clk); chk("R9 low", {8'd0, rd_data}, 16'h005A);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R9 high", {8'd0, rd_data}, 16'h00A5);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R9 wrap", {8'd0, rd_data}, 16'h005A);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    do_load(16'hA55A, 1'b0);
    @(negedge clk); chk("R9 load resets", {8'd0, rd_data}, 16'h005A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_binary();
    t_gate();
    t_bcd();
    t_latch();
    t_order();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule